// File: doc/BRIEF.md
# Serial Transmit Queue with Double Send Buffer

This block queues bytes for a synchronous serial transmitter and shifts them out MSB-first with a clock it generates itself. Bytes are written into a 32-entry queue. While transmit-enable is high, each byte moves from the queue into send stage A, then into send stage B, and then into the shifter. A level input, `tbemp_o`, shows when stage A is free to take a byte.

Software sets a fill-level threshold through a small command port. A one-cycle interrupt pulse marks the pop that brings the queue down to that level. In hold mode the queue stops feeding the send stages at that same pop. The stages and the shifter still drain, and then the serial clock rests high. This lets a fixed-length burst end by itself without a fresh enable.

Top module: `sertx_queue_top`

## Requirements
- R1: The queue holds up to DEPTH (32) bytes, and `level_o` shows the current count. A write to a full queue is dropped and sets `ovf_o`. `ovf_o` stays set until a clear.
- R2: `cmd_i` is decoded as follows. 2'b01 loads `thr_i` as the threshold, empties the queue and clears `ovf_o`. 2'b10 loads the threshold only. 2'b00 and 2'b11 change nothing. A clear takes priority over a write or a pop in the same cycle.
- R3: While `txe_i` is low, no byte leaves the queue and no byte enters the shifter.
- R4: Bytes pass in write order through stage A, then stage B, then the shifter. `tbemp_o` is high exactly when stage A holds no byte.
- R5: Each byte is sent MSB first on `sd_o`. `sclk_o` falls when the data changes and rises in mid-bit. Each clock phase lasts HALF system cycles.
- R6: `irq_o` is a one-cycle pulse. It comes in the cycle after a pop that leaves the level at or below the threshold, provided the level has been above the threshold since the last pulse or clear. A threshold of 0 fires on the pop that empties the queue.
- R7: With `hold_i` high, the pop that leaves the level at or below the threshold stops all further pops. Pops resume only after `txe_i` goes low or a clear is issued. The send stages still drain.
- R8: Once the last byte has shifted out, `sclk_o` stays high and `active_o` is low.
- R9: After reset: level 0, `ovf_o` low, `irq_o` low, `tbemp_o` high, `sclk_o` high, `active_o` low, threshold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the queue |
| wr_data_i | input | DW | Byte to enqueue |
| cmd_i | input | 2 | Command: 01 clear and load threshold, 10 load threshold |
| thr_i | input | TW | Threshold value to load |
| txe_i | input | 1 | Transmit enable |
| hold_i | input | 1 | Stop feeding the send stages at the threshold |
| irq_o | output | 1 | Threshold interrupt pulse |
| tbemp_o | output | 1 | Send stage A is empty |
| ovf_o | output | 1 | Sticky write-overflow flag |
| level_o | output | CW | Queue fill level |
| active_o | output | 1 | A byte is in a send stage or the shifter |
| sclk_o | output | 1 | Serial clock, idles high |
| sd_o | output | 1 | Serial data |

## Verification
A behavioural model in the bench tracks every output on every clock. The bench runs the block under five patterns, each separating one behaviour from its neighbours:
- A burst written while the enable is low, then released in hold mode with threshold 0. This shows that nothing moves before enable and that the pulse comes at the last pop.
- A threshold of 2 with hold off. This checks that the interrupt comes before shifting ends.
- A short refill that never climbs above the threshold. This proves the interrupt does not re-arm.
- A hold stop at threshold 3, with bytes left in the queue. This checks that the stop persists until the enable toggles.
- An overflow fill, then the reserved command, then a clear. This separates dropped writes, the sticky flag and the clear.

A receiver in the bench rebuilds the bytes from `sclk_o` and `sd_o`, so bit order is checked apart from the model.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    CMD_NONE     = 2'b00,
    CMD_CLR_LOAD = 2'b01,
    CMD_LOAD     = 2'b10,
    CMD_RSVD     = 2'b11
  } cmd_e;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] level_o,
  output logic [CW-1:0] level_nxt_o,
  output logic          empty_o,
  output logic          ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] level_q, level_d;
  logic          ovf_q, ovf_d;
  logic          full, push;

  assign full    = (level_q == CW'(DEPTH));
  assign push    = wr_i & ~clear_i & ~full;
  assign empty_o = (level_q == '0);
  assign rdata_o = mem_q[rptr_q];

  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    level_d = level_q + CW'(push) - CW'(pop_i);
    ovf_d   = ovf_q | (wr_i & full);
    if (push) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    if (pop_i) rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
    if (clear_i) begin
      wptr_d  = '0;
      rptr_d  = '0;
      level_d = '0;
      ovf_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      level_q <= level_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wptr_q] <= wdata_i;
  end

  assign level_o     = level_q;
  assign level_nxt_o = level_d;
  assign ovf_o       = ovf_q;

  // R1
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= CW'(DEPTH));
  // R1
  full_write_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clear_i && full) |=> ovf_q);
endmodule

// File: rtl/sertx_level.sv
module sertx_level #(
  parameter int TW = 6,
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          ld_i,
  input  logic [TW-1:0] thr_i,
  input  logic          pop_i,
  input  logic [CW-1:0] level_nxt_i,
  input  logic          txe_i,
  input  logic          hold_i,
  output logic          irq_o,
  output logic          halt_o
);
  logic [TW-1:0] thr_q, thr_d;
  logic          armed_q, armed_d, halt_q, halt_d, irq_q, irq_d;
  logic          at_or_below, fire;

  assign at_or_below = int'(level_nxt_i) <= int'(thr_q);
  assign fire        = armed_q & pop_i & at_or_below;

  always_comb begin
    thr_d   = ld_i ? thr_i : thr_q;
    irq_d   = fire;
    armed_d = ~at_or_below | (armed_q & ~fire);
    halt_d  = halt_q | (hold_i & pop_i & at_or_below);
    if (clear_i) armed_d = 1'b0;
    if (clear_i || !txe_i) halt_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q   <= '0;
      armed_q <= 1'b0;
      halt_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      thr_q   <= thr_d;
      armed_q <= armed_d;
      halt_q  <= halt_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_o  = irq_q;
  assign halt_o = halt_q;

  // R6
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  // R7
  halt_nopop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |-> !pop_i);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int DW   = 8,
  parameter int HALF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          txe_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  output logic          ready_o,
  output logic          tbemp_o,
  output logic          active_o,
  output logic          sclk_o,
  output logic          sd_o
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic          a_v_q, a_v_d, b_v_q, b_v_d;
  logic [DW-1:0] a_q, a_d, b_q, b_d, sh_q, sh_d;
  logic          busy_q, busy_d, sclk_q, sclk_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic          load, b_move, tick;

  assign load    = ~busy_q & b_v_q & txe_i;
  assign b_move  = a_v_q & (~b_v_q | load);
  assign ready_o = ~a_v_q | b_move;
  assign tick    = (hcnt_q == HW'(HALF - 1));

  always_comb begin
    a_v_d = a_v_q;  a_d = a_q;
    b_v_d = b_v_q;  b_d = b_q;
    if (b_move) begin
      b_v_d = 1'b1;  b_d = a_q;
    end else if (load) begin
      b_v_d = 1'b0;
    end
    if (push_i) begin
      a_v_d = 1'b1;  a_d = push_data_i;
    end else if (b_move) begin
      a_v_d = 1'b0;
    end
  end

  always_comb begin
    sh_d = sh_q;  busy_d = busy_q;  sclk_d = sclk_q;
    hcnt_d = hcnt_q;  bcnt_d = bcnt_q;
    if (load) begin
      sh_d = b_q;  busy_d = 1'b1;  sclk_d = 1'b0;
      hcnt_d = '0;  bcnt_d = '0;
    end else if (busy_q) begin
      if (!tick) begin
        hcnt_d = hcnt_q + HW'(1);
      end else begin
        hcnt_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
        end else if (bcnt_q == BW'(DW - 1)) begin
          busy_d = 1'b0;
        end else begin
          bcnt_d = bcnt_q + BW'(1);
          sclk_d = 1'b0;
          sh_d   = {sh_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_v_q <= 1'b0;  a_q <= '0;
      b_v_q <= 1'b0;  b_q <= '0;
      sh_q <= '0;  busy_q <= 1'b0;  sclk_q <= 1'b1;
      hcnt_q <= '0;  bcnt_q <= '0;
    end else begin
      a_v_q <= a_v_d;  a_q <= a_d;
      b_v_q <= b_v_d;  b_q <= b_d;
      sh_q <= sh_d;  busy_q <= busy_d;  sclk_q <= sclk_d;
      hcnt_q <= hcnt_d;  bcnt_q <= bcnt_d;
    end
  end

  assign tbemp_o  = ~a_v_q;
  assign active_o = busy_q | a_v_q | b_v_q;
  assign sclk_o   = sclk_q;
  assign sd_o     = sh_q[DW-1];

  // R5
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> sclk_q);
  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> $stable(sh_q[DW-1]));
  // R3
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txe_i && !busy_q) |=> !busy_q);
  // R4
  stage_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !tbemp_o);
endmodule

// File: rtl/sertx_queue_top.sv
module sertx_queue_top
  import sertx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int TW    = 6,
  parameter int HALF  = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    cmd_i,
  input  logic [TW-1:0] thr_i,
  input  logic          txe_i,
  input  logic          hold_i,
  output logic          irq_o,
  output logic          tbemp_o,
  output logic          ovf_o,
  output logic [CW-1:0] level_o,
  output logic          active_o,
  output logic          sclk_o,
  output logic          sd_o
);
  cmd_e          cmd;
  logic          clear, ld, pop, empty, halt, ready;
  logic [DW-1:0] head;
  logic [CW-1:0] level_nxt;

  assign cmd   = cmd_e'(cmd_i);
  assign clear = (cmd == CMD_CLR_LOAD);
  assign ld    = clear | (cmd == CMD_LOAD);
  assign pop   = txe_i & ~halt & ~empty & ~clear & ready;

  sertx_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .wr_i(wr_en_i),
    .wdata_i(wr_data_i), .pop_i(pop), .rdata_o(head), .level_o(level_o),
    .level_nxt_o(level_nxt), .empty_o(empty), .ovf_o(ovf_o)
  );

  sertx_level #(.TW(TW), .CW(CW)) u_level (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .ld_i(ld), .thr_i(thr_i),
    .pop_i(pop), .level_nxt_i(level_nxt), .txe_i(txe_i), .hold_i(hold_i),
    .irq_o(irq_o), .halt_o(halt)
  );

  sertx_shift #(.DW(DW), .HALF(HALF)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .txe_i(txe_i), .push_i(pop),
    .push_data_i(head), .ready_o(ready), .tbemp_o(tbemp_o),
    .active_o(active_o), .sclk_o(sclk_o), .sd_o(sd_o)
  );
endmodule

// File: tb/sertx_queue_top_tb.sv
module sertx_queue_top_tb_top;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cmd = 2'b00;
  logic [5:0] thr = '0;
  logic       txe = 1'b0;
  logic       hold = 1'b0;
  logic       irq, tbemp, ovf, active, sclk, sd;
  logic [5:0] level;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int irq_seen = 0;

  always #2.5 clk = ~clk;

  sertx_queue_top #(.HALF(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cmd_i(cmd), .thr_i(thr), .txe_i(txe), .hold_i(hold),
    .irq_o(irq), .tbemp_o(tbemp), .ovf_o(ovf), .level_o(level),
    .active_o(active), .sclk_o(sclk), .sd_o(sd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural reference
  bit [7:0] mq[$];
  int  m_thr, m_h, m_b;
  bit  m_armed, m_halt, m_irq, m_ovf, m_av, m_bv, m_busy, m_sclk;
  bit [7:0] m_ad, m_bd, m_sh;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      finish_sim();
    end
    if (!rst_n) begin
      mq.delete();
      m_thr = 0; m_h = 0; m_b = 0;
      m_armed = 0; m_halt = 0; m_irq = 0; m_ovf = 0;
      m_av = 0; m_bv = 0; m_busy = 0; m_sclk = 1;
      m_ad = 0; m_bd = 0; m_sh = 0;
    end else begin
      int sz, nsz;
      bit clr, ld, shl, bmv, rdy, pop, push, fire;
      bit [7:0] popped;
      sz   = mq.size();
      clr  = (cmd == 2'b01);
      ld   = clr || (cmd == 2'b10);
      shl  = !m_busy && m_bv && txe;
      bmv  = m_av && (!m_bv || shl);
      rdy  = !m_av || bmv;
      pop  = txe && !m_halt && sz > 0 && !clr && rdy;
      push = wr_en && !clr && sz < 32;
      nsz  = clr ? 0 : sz + int'(push) - int'(pop);
      fire = m_armed && pop && (nsz <= m_thr);
      popped = pop ? mq[0] : 8'h00;
      m_irq = fire;
      m_armed = clr ? 1'b0 : ((nsz > m_thr) || (m_armed && !fire));
      m_halt = (clr || !txe) ? 1'b0 : (m_halt || (hold && pop && nsz <= m_thr));
      m_ovf = clr ? 1'b0 : (m_ovf || (wr_en && sz == 32));
      // shifter
      if (shl) begin
        m_sh = m_bd; m_busy = 1; m_sclk = 0; m_h = 0; m_b = 0;
      end else if (m_busy) begin
        if (m_h != HALF - 1) m_h++;
        else begin
          m_h = 0;
          if (!m_sclk) m_sclk = 1;
          else if (m_b == 7) m_busy = 0;
          else begin m_b++; m_sclk = 0; m_sh = m_sh << 1; end
        end
      end
      if (bmv) begin m_bd = m_ad; m_bv = 1; end
      else if (shl) m_bv = 0;
      if (pop) begin m_ad = popped; m_av = 1; end
      else if (bmv) m_av = 0;
      if (clr) mq.delete();
      else begin
        if (pop) void'(mq.pop_front());
        if (push) mq.push_back(wr_data);
      end
      if (ld) m_thr = int'(thr);
      #1;
      check(sclk == m_sclk, "R5 sclk", sclk, m_sclk);
      check(sd == m_sh[7], "R5 sd", sd, m_sh[7]);
      check(irq == m_irq, "R6 irq", irq, m_irq);
      check(tbemp == !m_av, "R4 tbemp", tbemp, !m_av);
      check(ovf == m_ovf, "R1 ovf", ovf, m_ovf);
      check(int'(level) == mq.size(), "R1 level", level, mq.size());
      check(active == (m_busy || m_av || m_bv), "R8 active", active, m_busy || m_av || m_bv);
      if (irq) irq_seen++;
    end
  end

  // independent serial receiver
  bit [7:0] rx_q[$];
  bit [7:0] rx_sh;
  int rx_n = 0;
  always @(posedge sclk) begin
    if (rst_n) begin
      rx_sh = {rx_sh[6:0], sd};
      rx_n++;
      if (rx_n == 8) begin rx_q.push_back(rx_sh); rx_n = 0; end
    end
  end

  task automatic write_bytes(input bit [7:0] b[$]);
    foreach (b[i]) begin
      @(negedge clk); wr_en = 1'b1; wr_data = b[i];
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic issue(input logic [1:0] c, input logic [5:0] t);
    @(negedge clk); cmd = c; thr = t;
    @(negedge clk); cmd = 2'b00;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!active && level == 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit [7:0] burst[$];
    int irq_base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    check(level == 0, "R9 level", level, 0);
    check(ovf == 0, "R9 ovf", ovf, 0);
    check(irq == 0, "R9 irq", irq, 0);
    check(tbemp == 1, "R9 tbemp", tbemp, 1);
    check(sclk == 1, "R9 sclk", sclk, 1);
    check(active == 0, "R9 active", active, 0);

    // pattern 1: threshold 0, hold on, enable after writing
    issue(2'b01, 6'd0);
    hold = 1'b1;
    burst = '{8'hA5, 8'h3C, 8'h0F, 8'h81};
    write_bytes(burst);
    repeat (5) @(negedge clk);
    check(level == 4, "R3 level held while disabled", level, 4);
    check(tbemp == 1, "R3 stage A untouched", tbemp, 1);
    irq_base = irq_seen;
    txe = 1'b1;
    drain();
    check(irq_seen - irq_base == 1, "R6 one pulse at empty", irq_seen - irq_base, 1);
    check(rx_q.size() == 4, "R5 byte count", rx_q.size(), 4);
    foreach (burst[i]) if (i < rx_q.size())
      check(rx_q[i] == burst[i], "R4 R5 order and bits", rx_q[i], burst[i]);
    check(sclk == 1 && active == 0, "R8 clock parked high", sclk, 1);
    rx_q.delete();
    txe = 1'b0;
    @(negedge clk);

    // pattern 2: threshold 2, no hold
    hold = 1'b0;
    issue(2'b10, 6'd2);
    write_bytes('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66});
    check(level == 6, "R2 load-only keeps queue", level, 6);
    irq_base = irq_seen;
    txe = 1'b1;
    drain();
    check(irq_seen - irq_base == 1, "R6 pulse at level 2", irq_seen - irq_base, 1);
    check(rx_q.size() == 6, "R4 all bytes sent", rx_q.size(), 6);
    // short refill never above threshold: no re-arm
    irq_base = irq_seen;
    write_bytes('{8'hC3, 8'h5A});
    drain();
    check(irq_seen - irq_base == 0, "R6 not re-armed", irq_seen - irq_base, 0);
    rx_q.delete();
    txe = 1'b0;
    @(negedge clk);

    // pattern 3: hold stop at threshold 3
    issue(2'b01, 6'd3);
    hold = 1'b1;
    write_bytes('{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20});
    irq_base = irq_seen;
    txe = 1'b1;
    repeat (300) @(negedge clk);
    check(level == 3, "R7 halted at threshold", level, 3);
    check(active == 0 && sclk == 1, "R7 stages drained", active, 0);
    check(irq_seen - irq_base == 1, "R6 pulse at halt", irq_seen - irq_base, 1);
    txe = 1'b0;
    @(negedge clk);
    txe = 1'b1;
    repeat (100) @(negedge clk);
    check(level == 2, "R7 one byte per re-enable", level, 2);
    check(irq_seen - irq_base == 1, "R6 no second pulse", irq_seen - irq_base, 1);
    txe = 1'b0;
    @(negedge clk);

    // pattern 4: overflow, reserved command, clear
    hold = 1'b0;
    issue(2'b01, 6'd0);
    burst.delete();
    for (int i = 0; i < 34; i++) burst.push_back(8'(i));
    write_bytes(burst);
    check(level == 32, "R1 capacity", level, 32);
    check(ovf == 1, "R1 overflow sticky", ovf, 1);
    issue(2'b11, 6'd5);
    check(level == 32 && ovf == 1, "R2 reserved ignored", level, 32);
    issue(2'b01, 6'd0);
    check(level == 0, "R2 clear empties", level, 0);
    check(ovf == 0, "R2 clear drops flag", ovf, 0);
    txe = 1'b1;
    repeat (20) @(negedge clk);
    check(active == 0, "R2 nothing left to send", active, 0);
    txe = 1'b0;
    repeat (3) @(negedge clk);
    finish_sim();
  end
endmodule